// File: doc/BRIEF.md
# Normal Interrupt Priority Arbiter

This block arbitrates among the normal (not fast) interrupt sources of a sixty-four source interrupt controller. It holds one 4-bit priority per source and packs them eight to a 32-bit word. The register block next to it supplies the pending, enable and type vectors and the mask threshold. From these the arbiter drives the processor's normal interrupt line and a vector/status word that names the winning source.

A processor reads the vector word to learn which source to service. That read also consumes the interrupt. One cycle later the arbiter issues a clear request that carries the source index, and the register block drops that pending bit. The arbiter also answers bus reads of its priority words and of the two words that show the active normal sources. It accepts writes to the priority words and ignores writes to every other word.

Top module: `normal_prio_arbiter`

## Requirements
- R1: After reset every priority word (word addresses 8 to 15) reads as zero.
- R2: A write to word w, for w from 8 to 15, loads priority register 15-w. Source n takes its priority from bits [4*(n%8)+3 : 4*(n%8)] of register n/8. The written value reads back unchanged from the same word.
- R3: A source is an active normal source when its pending bit is 1, its enable bit is 1 and its type bit is 0. Word 23 reads the active-normal vector bits [31:0] and word 22 reads bits [63:32].
- R4: When the mask is 0x1F, `irq_o` is high exactly when at least one active normal source exists.
- R5: When the mask is any value other than 0x1F, `irq_o` is high exactly when some active normal source has a priority strictly greater than the mask. Mask values from 16 to 30 therefore keep `irq_o` low.
- R6: Word 16 returns the active normal source with the highest priority. The source number sits in bits [21:16], its priority in bits [3:0], and all other bits are zero.
- R7: When several active normal sources share the highest priority, word 16 names the highest-numbered one.
- R8: When no active normal source exists, word 16 reads 0xFFFFFFFF.
- R9: A read strobe on word 16 that finds a winner makes `clr_vld_o` high for exactly the next cycle, with `clr_idx_o` equal to the returned source number. Reads that find no winner, and reads of other words, raise no clear request.
- R10: A source whose type bit is 1 affects neither `irq_o`, word 16, nor words 22 and 23, whatever its priority.
- R11: Writes to words outside 8 to 15 leave every priority unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 64 | Pending bit per source |
| en_i | input | 64 | Enable bit per source |
| fast_i | input | 64 | Type bit per source, 1 marks a fast source |
| mask_i | input | 5 | Normal interrupt mask threshold |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (consumes the vector on word 16) |
| addr | input | 5 | Bus word address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for the word at `addr` |
| irq_o | output | 1 | Normal interrupt request |
| clr_vld_o | output | 1 | One-cycle request to clear a pending bit |
| clr_idx_o | output | 6 | Index of the source to clear |

## Verification
Three functions can meet in one cycle. A vector read can consume the winner while the threshold logic still drives `irq_o` from the same pending set. A priority write can also change the ranking of sources that are pending at that moment. The bench provokes this mix with random priority writes, sparse random pending, enable and type vectors, and random masks, then takes vector reads in turn. It removes each consumed source from its own pending model before the next step. It judges `irq_o`, both active-normal words, the vector word and the clear pulse against values it computes from its own priority model.

// File: rtl/narb_pkg.sv
// Package: shared word map and field positions of the normal priority arbiter.
// Assumes a 32-bit data bus addressed by word index.
package narb_pkg;
    localparam int PRIO_WORD_BASE = 8;    // lowest priority word address
    localparam int VEC_WORD       = 16;   // vector/status word
    localparam int NACT_HI_WORD   = 22;   // active normal sources, upper half
    localparam int NACT_LO_WORD   = 23;   // active normal sources, lower half
    localparam int VEC_IDX_LSB    = 16;   // source number position in vector word
endpackage

// File: rtl/narb_prio_store.sv
// Module: priority register file. It holds N_SRC priorities of PRIO_W bits,
// packed DATA_W/PRIO_W to a word. Word address PRIO_WORD_BASE+N_REG-1-r
// maps to register r. It exports the flat priority vector and a read word.
// Assumes N_SRC divisible by DATA_W/PRIO_W.
module narb_prio_store #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [N_SRC*PRIO_W-1:0]   prio_flat,
    output logic [DATA_W-1:0]         rd_word
);
    import narb_pkg::*;

    localparam int PER_WORD = DATA_W / PRIO_W;
    localparam int N_REG    = N_SRC / PER_WORD;
    localparam int TOP_WORD = PRIO_WORD_BASE + N_REG - 1;

    logic [DATA_W-1:0] regs [N_REG];

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_WORD = ADDR_W'(TOP_WORD - r);

        // Load register r on a write to its word; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[r] <= '0;
            else if (wr_en && addr == MY_WORD)
                regs[r] <= wdata;
        end

        assign prio_flat[r*DATA_W +: DATA_W] = regs[r];
    end

    // Select the register addressed by the bus for readback.
    always_comb begin
        rd_word = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (addr == ADDR_W'(TOP_WORD - r))
                rd_word = regs[r];
        end
    end
endmodule

// File: rtl/narb_max_tree.sv
// Module: balanced comparison tree. It finds the active source with the
// largest priority. At equal priority the higher-numbered source wins.
// Heap layout: leaf of source i is node N_SRC+i, node k has children 2k
// (lower indices) and 2k+1 (higher indices). Assumes N_SRC is a power of two.
module narb_max_tree #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]          active,
    input  logic [N_SRC*PRIO_W-1:0]   prio_flat,
    output logic                      win_vld,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    localparam int N_NODE = 2 * N_SRC;

    logic              nv [N_NODE];
    logic [PRIO_W-1:0] np [N_NODE];
    logic [IDX_W-1:0]  ni [N_NODE];

    // Node 0 is outside the heap; tie it off.
    assign nv[0] = 1'b0;
    assign np[0] = '0;
    assign ni[0] = '0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_leaf
        assign nv[N_SRC+i] = active[i];
        assign np[N_SRC+i] = prio_flat[i*PRIO_W +: PRIO_W];
        assign ni[N_SRC+i] = IDX_W'(i);
    end

    for (genvar k = 1; k < N_SRC; k++) begin : g_node
        logic take_hi;
        // Prefer the higher-index child when its priority is equal or larger.
        assign take_hi = nv[2*k+1] && (!nv[2*k] || np[2*k+1] >= np[2*k]);
        assign nv[k]   = nv[2*k] | nv[2*k+1];
        assign np[k]   = take_hi ? np[2*k+1] : np[2*k];
        assign ni[k]   = take_hi ? ni[2*k+1] : ni[2*k];
    end

    assign win_vld  = nv[1];
    assign win_idx  = ni[1];
    assign win_prio = np[1];
endmodule

// File: rtl/narb_threshold.sv
// Module: interrupt line generator. It compares every active source's
// priority with the mask in parallel. An all-ones mask bypasses the filter.
// Assumes MASK_W > PRIO_W so that the all-ones mask exceeds any priority.
module narb_threshold #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5
) (
    input  logic [N_SRC-1:0]          active,
    input  logic [N_SRC*PRIO_W-1:0]   prio_flat,
    input  logic [MASK_W-1:0]         mask,
    output logic                      irq
);
    logic [N_SRC-1:0] over;

    for (genvar n = 0; n < N_SRC; n++) begin : g_cmp
        assign over[n] = active[n] &&
            (MASK_W'(prio_flat[n*PRIO_W +: PRIO_W]) > mask);
    end

    // Raise the line for any source above threshold, or any source when bypassed.
    always_comb begin
        if (mask == '1)
            irq = |active;
        else
            irq = |over;
    end
endmodule

// File: rtl/normal_prio_arbiter.sv
// Module: top of the normal interrupt priority arbiter. It derives the active
// normal set, runs the threshold and the comparison tree, answers bus reads
// and issues a registered one-cycle clear request after a vector read that
// finds a winner. Assumes N_SRC = 2*DATA_W for the two active-normal words.
module normal_prio_arbiter #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    parameter int MASK_W = 5,
    parameter int ADDR_W = 5,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [N_SRC-1:0]  en_i,
    input  logic [N_SRC-1:0]  fast_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              clr_vld_o,
    output logic [IDX_W-1:0]  clr_idx_o
);
    import narb_pkg::*;

    localparam int N_REG = N_SRC / (DATA_W / PRIO_W);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_WORD);
    localparam logic [ADDR_W-1:0] A_NHI  = ADDR_W'(NACT_HI_WORD);
    localparam logic [ADDR_W-1:0] A_NLO  = ADDR_W'(NACT_LO_WORD);
    localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(PRIO_WORD_BASE);
    localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(PRIO_WORD_BASE + N_REG - 1);

    logic [N_SRC-1:0]        active;
    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic [DATA_W-1:0]       prio_word;
    logic                    win_vld;
    logic [IDX_W-1:0]        win_idx;
    logic [PRIO_W-1:0]       win_prio;
    logic [DATA_W-1:0]       vec_word;

    assign active = pend_i & en_i & ~fast_i;

    narb_prio_store #(
        .N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .prio_flat(prio_flat), .rd_word(prio_word)
    );

    narb_max_tree #(
        .N_SRC(N_SRC), .PRIO_W(PRIO_W)
    ) i_tree (
        .active(active), .prio_flat(prio_flat),
        .win_vld(win_vld), .win_idx(win_idx), .win_prio(win_prio)
    );

    narb_threshold #(
        .N_SRC(N_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)
    ) i_thresh (
        .active(active), .prio_flat(prio_flat), .mask(mask_i), .irq(irq_o)
    );

    // Assemble the vector/status word, or the all-ones empty code.
    always_comb begin
        vec_word = '0;
        if (win_vld) begin
            vec_word[VEC_IDX_LSB +: IDX_W] = win_idx;
            vec_word[0 +: PRIO_W]          = win_prio;
        end else begin
            vec_word = '1;
        end
    end

    // Bus read multiplexer over the words this block owns.
    always_comb begin
        if (addr >= A_PLO && addr <= A_PHI)
            rdata = prio_word;
        else if (addr == A_VEC)
            rdata = vec_word;
        else if (addr == A_NHI)
            rdata = active[N_SRC-1 -: DATA_W];
        else if (addr == A_NLO)
            rdata = active[DATA_W-1:0];
        else
            rdata = '0;
    end

    // Register the clear request one cycle after a consuming vector read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_vld_o <= 1'b0;
            clr_idx_o <= '0;
        end else begin
            clr_vld_o <= rd_en && (addr == A_VEC) && win_vld;
            clr_idx_o <= win_idx;
        end
    end
endmodule

// File: rtl/narb_checker.sv
// Module: property checker for normal_prio_arbiter, bound to every instance.
// Assumes the default 64-source, 4-bit priority, 32-bit word configuration.
module narb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] pend_i,
    input logic [63:0] en_i,
    input logic [63:0] fast_i,
    input logic [4:0]  mask_i,
    input logic        wr_en,
    input logic        rd_en,
    input logic [4:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        irq_o,
    input logic        clr_vld_o,
    input logic [5:0]  clr_idx_o
);
    logic [63:0] normal;
    assign normal = pend_i & en_i & ~fast_i;

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (normal == 64'd0) |-> !irq_o); // R4
    AST_IRQ_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == 5'h1F && normal != 64'd0) |-> irq_o); // R4
    AST_IRQ_HIGH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i >= 5'd16 && mask_i != 5'h1F) |-> !irq_o); // R5
    AST_PEND_LO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd23) |-> (rdata == normal[31:0])); // R3
    AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd16 && normal != 64'd0) |->
            (rdata[31:22] == 10'd0 && rdata[15:4] == 12'd0)); // R6
    AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd16 && normal == 64'd0) |-> (rdata == 32'hFFFF_FFFF)); // R8
    AST_CLR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'd16 && normal != 64'd0) |=>
            (clr_vld_o && clr_idx_o == $past(rdata[21:16]))); // R9
    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vld_o |-> $past(rd_en && addr == 5'd16 && normal != 64'd0)); // R9
    AST_PRIO_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= 5'd8 && addr <= 5'd15) |=>
            (addr != $past(addr) || rdata == $past(wdata))); // R2
endmodule

bind normal_prio_arbiter narb_checker i_chk (.*);

// File: tb/test_normal_prio_arbiter.sv
`timescale 1ns/1ps
module test_normal_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pend_i = '0, en_i = '0, fast_i = '0;
    logic [4:0]  mask_i = 5'h1F;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, clr_vld_o;
    logic [5:0]  clr_idx_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [3:0] pm [64];

    normal_prio_arbiter i_normal_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .fast_i(fast_i),
        .mask_i(mask_i), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
        .clr_vld_o(clr_vld_o), .clr_idx_o(clr_idx_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] act_vec();
        return pend_i & en_i & ~fast_i;
    endfunction

    function automatic logic exp_irq();
        logic [63:0] a = act_vec();
        logic hit = 1'b0;
        if (mask_i == 5'h1F) return |a;
        for (int i = 0; i < 64; i++)
            if (a[i] && {1'b0, pm[i]} > mask_i) hit = 1'b1;
        return hit;
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [63:0] a = act_vec();
        int best = -1;
        int bi = 0;
        for (int i = 0; i < 64; i++)
            if (a[i] && int'(pm[i]) >= best) begin best = int'(pm[i]); bi = i; end
        if (best < 0) return 32'hFFFF_FFFF;
        return (32'(bi) << 16) | 32'(best);
    endfunction

    function automatic logic [31:0] exp_prio_word(input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < 8; k++) v[4*k +: 4] = pm[(15 - w)*8 + k];
        return v;
    endfunction

    task automatic write_word(input int w, input logic [31:0] d);
        @(negedge clk);
        addr = 5'(w); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (w >= 8 && w <= 15)
            for (int k = 0; k < 8; k++) pm[(15 - w)*8 + k] = d[4*k +: 4];
    endtask

    task automatic check_prio_words(input string req);
        for (int w = 8; w <= 15; w++) begin
            addr = 5'(w); #1;
            check(rdata == exp_prio_word(w), req, rdata, exp_prio_word(w));
        end
    endtask

    task automatic check_static(input string req_irq);
        #1;
        check(irq_o == exp_irq(), req_irq, 32'(irq_o), 32'(exp_irq()));
        addr = 5'd22; #1;
        check(rdata == act_vec()[63:32], "R3 word22", rdata, act_vec()[63:32]);
        addr = 5'd23; #1;
        check(rdata == act_vec()[31:0], "R3 word23", rdata, act_vec()[31:0]);
    endtask

    // Consuming vector read; bench removes the winner from its pending vector.
    task automatic read_vec(input string req);
        logic [31:0] e;
        @(negedge clk);
        addr = 5'd16; rd_en = 1'b1; #2;
        e = exp_vec();
        check(rdata == e, req, rdata, e);
        @(negedge clk);
        rd_en = 1'b0; #1;
        check(clr_vld_o == (e != 32'hFFFF_FFFF), "R9 clr_vld", 32'(clr_vld_o),
              32'(e != 32'hFFFF_FFFF));
        if (e != 32'hFFFF_FFFF) begin
            check(clr_idx_o == e[21:16], "R9 clr_idx", 32'(clr_idx_o), 32'(e[21:16]));
            pend_i[e[21:16]] = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) pm[i] = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: priorities reset to zero
        check_prio_words("R1 reset prio");
        check_static("R4 reset irq");

        // R2: word/register mapping
        write_word(15, 32'h7654_3210);
        write_word(8,  32'hFEDC_BA98);
        write_word(11, 32'h1357_9BDF);
        check_prio_words("R2 prio map");

        // R11: writes to other words ignored
        write_word(16, 32'hFFFF_FFFF);
        write_word(22, 32'hAAAA_AAAA);
        write_word(3,  32'h5555_5555);
        check_prio_words("R11 ignored write");

        // R7: tie at equal priority -> higher index; consume then lower
        for (int w = 8; w <= 15; w++) write_word(w, 32'h0);
        write_word(15, 32'h0090_0000);   // source 5 prio 9
        write_word(10, 32'h0000_0009);   // source 40 prio 9
        pend_i = '0; pend_i[5] = 1'b1; pend_i[40] = 1'b1;
        en_i = '1; fast_i = '0; mask_i = 5'd3;
        check_static("R5 tie irq");
        read_vec("R7 tie winner 40");
        read_vec("R7 then source 5");
        read_vec("R8 empty vector");
        @(negedge clk); #1;
        check(clr_vld_o == 1'b0, "R9 single pulse", 32'(clr_vld_o), 32'd0);

        // R10: fast source with high priority is invisible
        write_word(8, 32'hF000_0000);    // source 63 prio 15
        pend_i = '0; pend_i[63] = 1'b1; fast_i[63] = 1'b1;
        mask_i = 5'h1F;
        check_static("R10 fast irq");
        read_vec("R10 fast vector");

        // R5 boundary: priority equal to mask vs one above
        fast_i = '0; pend_i = '0; pend_i[40] = 1'b1;   // prio 9
        mask_i = 5'd9;  check_static("R5 equal mask");
        mask_i = 5'd8;  check_static("R5 above mask");
        mask_i = 5'd20; check_static("R5 high mask");
        mask_i = 5'h1F; check_static("R4 bypass");
        read_vec("R6 vector format");

        // Random mix of writes, vectors, masks and reads
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 2) == 0)
                write_word($urandom_range(8, 15), $urandom);
            pend_i = {$urandom, $urandom} & {$urandom, $urandom};
            en_i   = {$urandom, $urandom} | {$urandom, $urandom};
            fast_i = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 9) == 0) pend_i = '0;
            mask_i = ($urandom_range(0, 3) == 0) ? 5'h1F : 5'($urandom_range(0, 17));
            check_static("R5 random irq");
            read_vec("R6 random vector");
            read_vec("R7 random vector");
            check_static("R4 random irq after clear");
        end
        check_prio_words("R2 random readback");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule